// File: doc/BRIEF.md
# Debug Service Control Engine

This block sits behind a small debug register window and runs three long operations for an external debugger: a whole-device erase, a built-in self test of an internal RAM, and a checksum over a RAM range. The debugger programs a start address and a length, writes a start bit, and polls the status word. The operation has finished once any of the done, fail or protection-error flags is set. The engine also holds the processor in an extended reset after power-up, until the debugger writes a release bit.

A protection flag, set from outside by a pulse, locks out the self test and the checksum. Only the erase may run while the flag is set, and a finished erase clears it. The self test runs a six-phase march over a small RAM model. That model can be given one stuck-at bit fault. When the test finds a mismatch it stops and reports the failing byte address, the bit index and the phase.

Register window (two-bit word index): 0 control/status, 1 address, 2 length, 3 data. Sequencer states: IDLE, ERASE, MARCH and CRC. A start command moves IDLE to ERASE, MARCH or CRC, or to a result at once. ERASE returns to IDLE when its timer expires. MARCH and CRC return to IDLE when their engine signals that it has finished.

Top module: `dse_engine`

## Requirements
- R1: After reset, the control/status word reads 0x0000_0200 (only the extended-reset bit 9 set), core_hold is 1, and the address, length and data registers read 0.
- R2: Writing a control word with bit 9 set clears bit 9 and drops core_hold. A write with bit 9 clear has no effect on it. Once released, core_hold stays 0 until the next reset.
- R3: Status bits done (8), fail (11) and protection error (12) each clear when the control word is written with a 1 in that bit. A 0 leaves the bit unchanged. At most one of the three is set at any time.
- R4: Start bits are erase (4), self test (3) and checksum (2). When several are set in one write, erase takes priority over self test, and self test over checksum. An accepted start clears done, fail, bus error (10) and protection error.
- R5: While an operation runs, start bits are ignored, and writes to the address and length registers are ignored.
- R6: A pulse on prot_set sets the protected bit 16. While that bit is set, a self test or checksum start leaves the engine idle and sets protection error on the next cycle. Done stays clear and the RAM is not touched.
- R7: An erase lasts ERASE_CYCLES cycles, may run while protected, and ends with protected cleared and done set.
- R8: The address register holds a byte address whose bits 1:0 are a mode field that the engine keeps but does not use. The length register holds a byte length in bits 31:2; its bits 1:0 are ignored. The word count is therefore register >> 4, and the start word is address >> 2.
- R9: The self test runs six phases over the range: 0 up(w0), 1 up(r0,w1), 2 up(r1,w0), 3 down(r0,w1), 4 down(r1,w0), 5 up(r0). Without a fault it ends with done set and all words in the range left at 0.
- R10: At the first mismatch the self test stops and sets fail. The address register then reads failing word × 4 with the mode bits kept. Data bits 4:0 give the lowest mismatching bit, bits 15:8 give the phase, and all other data bits are 0. A stuck-at-1 cell fails in phase 1 and a stuck-at-0 cell fails in phase 2.
- R11: If start word + word count exceeds RAM_DEPTH, a self test or checksum sets bus error and fail without touching the RAM. A word count of 0 sets done at once.
- R12: The checksum is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. Each word is fed most significant bit first, with no reflection and no final inversion. The result goes to the data register and done is set.
- R13: A fault on a word outside the tested range does not affect the self test result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| prot_set | input | 1 | Pulse that sets the protected state |
| flt_en | input | 1 | Enables the injected stuck-at fault |
| flt_word | input | $clog2(RAM_DEPTH) | Word holding the faulty cell |
| flt_bit | input | $clog2(DATA_W) | Bit index of the faulty cell |
| flt_val | input | 1 | Stuck-at value of the faulty cell |
| core_hold | output | 1 | Extended reset hold for the processor |

## Verification
The self test is swept over every word of the full range, at the lowest, a middle and the highest bit, with both stuck-at polarities. This separates the phase-1 detection of stuck-at-1 from the phase-2 detection of stuck-at-0, and checks the reported address and bit for each cell. A partial window with faults just inside and just outside it separates range handling from address wrap. The checksum is compared with a CRC computed in the bench, once over zeroed RAM (which also shows that a clean test leaves zeros) and once with a stuck bit in the window. Priority, protection gating, busy-time writes and the release bit are each driven with a pattern whose two possible outcomes differ at the ports.

// File: rtl/dse_pkg.sv
package dse_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ERASE = 2'd1,
        S_MARCH = 2'd2,
        S_CRC   = 2'd3
    } seq_state_t;

    localparam int REG_CTL  = 0;
    localparam int REG_ADDR = 1;
    localparam int REG_LEN  = 2;
    localparam int REG_DATA = 3;

    localparam int B_CRC   = 2;
    localparam int B_MBIST = 3;
    localparam int B_ERASE = 4;
    localparam int B_DONE  = 8;
    localparam int B_XRST  = 9;
    localparam int B_BERR  = 10;
    localparam int B_FAIL  = 11;
    localparam int B_PERR  = 12;
    localparam int B_PROT  = 16;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/dse_ram.sv
module dse_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic          flt_en,
    input  logic [AW-1:0] flt_word,
    input  logic [BW-1:0] flt_bit,
    input  logic          flt_val
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Stuck-at cell: forced on the read side
    always_comb begin
        rdata = mem[raddr];
        if (flt_en && raddr == flt_word) rdata[flt_bit] = flt_val;
    end
endmodule

// File: rtl/dse_march.sv
module dse_march #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  rd_data,
    output logic          we,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          fin,
    output logic          ok,
    output logic [AW-1:0] f_word,
    output logic [BW-1:0] f_bit,
    output logic [7:0]    f_phase
);
    localparam int LAST_PHASE = 5;

    logic          active;
    logic [2:0]    phase;
    logic [CW-1:0] idx;
    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;

    logic          down, exp_v, wr_v, has_wr, mism, last_el;
    logic [CW-1:0] off;
    logic [AW-1:0] cur;
    logic [W-1:0]  diff;
    logic [BW-1:0] low_bit;

    always_comb begin
        down    = (phase == 3'd3) || (phase == 3'd4);
        exp_v   = (phase == 3'd2) || (phase == 3'd4);
        wr_v    = (phase == 3'd1) || (phase == 3'd3);
        has_wr  = (phase != 3'(LAST_PHASE));
        off     = down ? (cnt_q - 1'b1 - idx) : idx;
        cur     = base_q + off[AW-1:0];
        diff    = rd_data ^ {W{exp_v}};
        mism    = active && (phase != 3'd0) && (diff != '0);
        last_el = (idx == cnt_q - 1'b1);
        low_bit = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (diff[i]) low_bit = BW'(i);
        end
    end

    assign rd_addr = cur;
    assign wr_addr = cur;
    assign wr_data = {W{wr_v}};
    assign we      = active && !mism && has_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= '0;
            idx     <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            fin     <= 1'b0;
            ok      <= 1'b0;
            f_word  <= '0;
            f_bit   <= '0;
            f_phase <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                phase  <= '0;
                idx    <= '0;
                base_q <= base;
                cnt_q  <= cnt;
            end else if (active) begin
                if (mism) begin
                    active  <= 1'b0;
                    fin     <= 1'b1;
                    ok      <= 1'b0;
                    f_word  <= cur;
                    f_bit   <= low_bit;
                    f_phase <= {5'b0, phase};
                end else if (last_el) begin
                    idx <= '0;
                    if (phase == 3'(LAST_PHASE)) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                        ok     <= 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dse_crc.sv
module dse_crc #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic          fin,
    output logic [31:0]   result
);
    import dse_pkg::*;

    logic          active;
    logic [CW-1:0] idx;
    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            r = (r[31] ^ d[i]) ? ({r[30:0], 1'b0} ^ CRC_POLY) : {r[30:0], 1'b0};
        end
        return r;
    endfunction

    assign rd_addr = base_q + idx[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            fin    <= 1'b0;
            result <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                idx    <= '0;
                base_q <= base;
                cnt_q  <= cnt;
                result <= 32'hFFFF_FFFF;
            end else if (active) begin
                result <= crc_word(result, rd_data);
                if (idx == cnt_q - 1'b1) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dse_engine.sv
module dse_engine #(
    parameter int RAM_DEPTH    = 16,
    parameter int DATA_W       = 32,
    parameter int ERASE_CYCLES = 64,
    localparam int AW          = $clog2(RAM_DEPTH),
    localparam int CW          = $clog2(RAM_DEPTH + 1),
    localparam int BW          = $clog2(DATA_W),
    localparam int EW          = $clog2(ERASE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          prot_set,
    input  logic          flt_en,
    input  logic [AW-1:0] flt_word,
    input  logic [BW-1:0] flt_bit,
    input  logic          flt_val,
    output logic          core_hold
);
    import dse_pkg::*;

    seq_state_t state_q, state_d;

    logic st_done, st_fail, st_berr, st_perr, xrst_q, prot_q;
    logic [31:0]   addr_q, len_q, data_q;
    logic [EW-1:0] ers_cnt;

    // start decode
    logic          wr_ctl, idle, req_erase, req_mb, req_crc, req_any;
    logic [31:0]   span;
    logic          range_ok;
    logic [AW-1:0] start_w;
    logic [CW-1:0] n_words;
    logic          run_ok, mb_go, crc_go, erase_end;

    // engines and RAM
    logic [AW-1:0] mb_rd, crc_rd, ram_raddr, ram_waddr;
    logic [DATA_W-1:0] ram_rdata, ram_wdata;
    logic          ram_we, mb_fin, mb_ok, crc_fin;
    logic [AW-1:0] f_word;
    logic [BW-1:0] f_bit;
    logic [7:0]    f_phase;
    logic [31:0]   crc_res;

    always_comb begin
        wr_ctl    = reg_wr && (reg_addr == 2'(REG_CTL));
        idle      = (state_q == S_IDLE);
        req_erase = wr_ctl && idle && reg_wdata[B_ERASE];
        req_mb    = wr_ctl && idle && !reg_wdata[B_ERASE] && reg_wdata[B_MBIST];
        req_crc   = wr_ctl && idle && !reg_wdata[B_ERASE] && !reg_wdata[B_MBIST]
                    && reg_wdata[B_CRC];
        req_any   = req_erase || req_mb || req_crc;
        span      = {2'b0, addr_q[31:2]} + {4'b0, len_q[31:4]};
        range_ok  = (span <= 32'(RAM_DEPTH));
        start_w   = addr_q[AW+1:2];
        n_words   = len_q[CW+3:4];
        run_ok    = !prot_q && range_ok && (n_words != '0);
        mb_go     = req_mb && run_ok;
        crc_go    = req_crc && run_ok;
        erase_end = (state_q == S_ERASE) && (ers_cnt == EW'(ERASE_CYCLES - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_erase)   state_d = S_ERASE;
                else if (mb_go)  state_d = S_MARCH;
                else if (crc_go) state_d = S_CRC;
            end
            S_ERASE: if (erase_end) state_d = S_IDLE;
            S_MARCH: if (mb_fin)    state_d = S_IDLE;
            S_CRC:   if (crc_fin)   state_d = S_IDLE;
        endcase
    end

    // status, registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_fail <= 1'b0;
            st_berr <= 1'b0;
            st_perr <= 1'b0;
            xrst_q  <= 1'b1;
            prot_q  <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            data_q  <= '0;
            ers_cnt <= '0;
        end else begin
            if (wr_ctl) begin
                if (reg_wdata[B_DONE]) st_done <= 1'b0;
                if (reg_wdata[B_FAIL]) st_fail <= 1'b0;
                if (reg_wdata[B_PERR]) st_perr <= 1'b0;
                if (reg_wdata[B_XRST]) xrst_q  <= 1'b0;
            end
            if (reg_wr && idle && reg_addr == 2'(REG_ADDR)) addr_q <= reg_wdata;
            if (reg_wr && idle && reg_addr == 2'(REG_LEN))  len_q  <= reg_wdata;

            if (req_any) begin
                st_done <= 1'b0;
                st_fail <= 1'b0;
                st_berr <= 1'b0;
                st_perr <= 1'b0;
                ers_cnt <= '0;
                if (!req_erase) begin
                    if (prot_q) begin
                        st_perr <= 1'b1;
                    end else if (!range_ok) begin
                        st_berr <= 1'b1;
                        st_fail <= 1'b1;
                    end else if (n_words == '0) begin
                        st_done <= 1'b1;
                    end
                end
            end

            unique case (state_q)
                S_IDLE: ;
                S_ERASE: begin
                    ers_cnt <= ers_cnt + 1'b1;
                    if (erase_end) begin
                        prot_q  <= 1'b0;
                        st_done <= 1'b1;
                    end
                end
                S_MARCH: begin
                    if (mb_fin && mb_ok) st_done <= 1'b1;
                    if (mb_fin && !mb_ok) begin
                        st_fail <= 1'b1;
                        addr_q  <= {{(30 - AW){1'b0}}, f_word, addr_q[1:0]};
                        data_q  <= {16'h0, f_phase, 8'(f_bit)};
                    end
                end
                S_CRC: begin
                    if (crc_fin) begin
                        st_done <= 1'b1;
                        data_q  <= crc_res;
                    end
                end
            endcase

            if (prot_set) prot_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            2'(REG_CTL):  reg_rdata = (32'(prot_q) << B_PROT) | (32'(st_perr) << B_PERR)
                                    | (32'(st_fail) << B_FAIL) | (32'(st_berr) << B_BERR)
                                    | (32'(xrst_q) << B_XRST) | (32'(st_done) << B_DONE);
            2'(REG_ADDR): reg_rdata = addr_q;
            2'(REG_LEN):  reg_rdata = len_q;
            default:      reg_rdata = data_q;
        endcase
    end

    assign core_hold = xrst_q;
    assign ram_raddr = (state_q == S_CRC) ? crc_rd : mb_rd;

    dse_ram #(.DEPTH(RAM_DEPTH), .W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata), .flt_en(flt_en), .flt_word(flt_word),
        .flt_bit(flt_bit), .flt_val(flt_val)
    );

    dse_march #(.DEPTH(RAM_DEPTH), .W(DATA_W)) u_march (
        .clk(clk), .rst_n(rst_n), .go(mb_go), .base(start_w), .cnt(n_words),
        .rd_addr(mb_rd), .rd_data(ram_rdata), .we(ram_we), .wr_addr(ram_waddr),
        .wr_data(ram_wdata), .fin(mb_fin), .ok(mb_ok), .f_word(f_word),
        .f_bit(f_bit), .f_phase(f_phase)
    );

    dse_crc #(.DEPTH(RAM_DEPTH)) u_crc (
        .clk(clk), .rst_n(rst_n), .go(crc_go), .base(start_w), .cnt(n_words),
        .rd_addr(crc_rd), .rd_data(ram_rdata), .fin(crc_fin), .result(crc_res)
    );
endmodule

// File: rtl/dse_engine_chk.sv
module dse_engine_chk (
    input logic                clk,
    input logic                rst_n,
    input dse_pkg::seq_state_t state_q,
    input dse_pkg::seq_state_t state_d,
    input logic                st_done,
    input logic                st_fail,
    input logic                st_perr,
    input logic                prot_q,
    input logic                prot_set,
    input logic [31:0]         len_q,
    input logic                core_hold,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic [31:0]         reg_wdata
);
    import dse_pkg::*;

    p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_done, st_fail, st_perr}));

    p_hold_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |=> !core_hold);

    p_prot_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && prot_q && reg_wr && reg_addr == 2'd0 && !reg_wdata[4]
         && (reg_wdata[3] || reg_wdata[2])) |=> (st_perr && !st_done && state_q == S_IDLE));

    p_len_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && reg_wr && reg_addr == 2'd2) |=> $stable(len_q));

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MARCH && reg_wr && reg_addr == 2'd0) |=> (state_q != S_ERASE));

    p_erase_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ERASE && state_d == S_IDLE && !prot_set) |=> (st_done && !prot_q));
endmodule

bind dse_engine dse_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_d(state_d),
    .st_done(st_done), .st_fail(st_fail), .st_perr(st_perr), .prot_q(prot_q),
    .prot_set(prot_set), .len_q(len_q), .core_hold(core_hold), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/dse_engine_bench.sv
`timescale 1ns/1ps
module dse_engine_bench;
    localparam int DEPTH = 16;
    localparam int ERASE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        prot_set = 1'b0;
    logic        flt_en = 1'b0;
    logic [3:0]  flt_word = '0;
    logic [4:0]  flt_bit = '0;
    logic        flt_val = 1'b0;
    logic        core_hold;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    dse_engine #(.RAM_DEPTH(DEPTH), .DATA_W(32), .ERASE_CYCLES(ERASE)) u_dse_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_set(prot_set),
        .flt_en(flt_en), .flt_word(flt_word), .flt_bit(flt_bit), .flt_val(flt_val),
        .core_hold(core_hold)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_end(output logic [31:0] st);
        st = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, st);
            if ((st & 32'h1900) != 0) break;
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            logic fb = r[31] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    task automatic run_op(input logic [31:0] base, input logic [31:0] words,
                          input logic [31:0] cmd, output logic [31:0] st);
        wr(2'd1, (base << 2) | 32'h1);
        wr(2'd2, (words * 4) << 2);
        wr(2'd0, cmd);
        wait_end(st);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st, exp_crc, d_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctl", v, 32'h200);
        check("R1 hold", 32'(core_hold), 32'd1);
        rd(2'd1, v); check("R1 addr", v, 0);
        rd(2'd2, v); check("R1 len", v, 0);
        rd(2'd3, v); check("R1 data", v, 0);

        // R2 release
        wr(2'd0, 32'h0);
        check("R2 zero write keeps hold", 32'(core_hold), 32'd1);
        wr(2'd0, 32'h200);
        rd(2'd0, v); check("R2 bit9 cleared", v, 32'h0);
        check("R2 hold released", 32'(core_hold), 32'd0);

        // R11 zero count and out of range
        run_op(0, 0, 32'h8, st); check("R11 zero count done", st, 32'h100);
        run_op(12, 8, 32'h8, st); check("R11 out of range", st, 32'hC00);

        // R3 W1C leaves others
        wr(2'd0, 32'h100);
        rd(2'd0, v); check("R3 done W1C keeps berr/fail", v, 32'hC00);
        wr(2'd0, 32'h800);
        rd(2'd0, v); check("R3 fail W1C", v, 32'h400);

        // R9 clean test, then R12 checksum over zeroed RAM
        run_op(0, DEPTH, 32'h8, st); check("R9 clean pass", st, 32'h100);
        run_op(0, DEPTH, 32'h4, st); check("R12 crc done", st, 32'h100);
        exp_crc = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++) exp_crc = crc_ref(exp_crc, 0);
        rd(2'd3, v); check("R9 R12 crc of zero RAM", v, exp_crc);

        // R12 checksum with a stuck bit in the window
        flt_en = 1'b1; flt_word = 4'd5; flt_bit = 5'd3; flt_val = 1'b1;
        run_op(2, 7, 32'h4, st);
        exp_crc = 32'hFFFF_FFFF;
        for (int i = 2; i < 9; i++) exp_crc = crc_ref(exp_crc, (i == 5) ? 32'h8 : 32'h0);
        rd(2'd3, v); check("R12 crc with stuck bit", v, exp_crc);

        // R4 priority: MBIST over checksum (fault makes MBIST fail)
        run_op(0, DEPTH, 32'hC, st); check("R4 mbist beats crc", st, 32'h800);
        flt_en = 1'b0;
        run_op(0, DEPTH, 32'h8, st); check("R9 restore", st, 32'h100);

        // R10 sweep of every cell position and polarity
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [4:0] bi = (b == 0) ? 5'd0 : (b == 1) ? 5'd13 : 5'd31;
                    flt_en = 1'b1; flt_word = 4'(a); flt_bit = bi; flt_val = 1'(p);
                    run_op(0, DEPTH, 32'h8, st);
                    check("R10 status", st, 32'h800);
                    rd(2'd1, v); check("R10 fail address", v, 32'(a * 4) | 32'h1);
                    rd(2'd3, v);
                    check("R10 bit and phase", v, ((p == 1) ? 32'h100 : 32'h200) | 32'(bi));
                end
            end
        end
        flt_en = 1'b0;
        run_op(0, DEPTH, 32'h8, st); check("R9 restore 2", st, 32'h100);

        // R13 window 4..11: fault outside passes, inside fails
        flt_en = 1'b1; flt_word = 4'd2; flt_bit = 5'd7; flt_val = 1'b1;
        run_op(4, 8, 32'h8, st); check("R13 fault below window", st, 32'h100);
        flt_word = 4'd12;
        run_op(4, 8, 32'h8, st); check("R13 fault above window", st, 32'h100);
        flt_word = 4'd11;
        run_op(4, 8, 32'h8, st); check("R10 last window word", st, 32'h800);
        rd(2'd1, v); check("R10 last window addr", v, 32'd44 | 32'h1);
        flt_en = 1'b0;
        run_op(0, DEPTH, 32'h8, st);

        // R5 writes during a run are ignored
        rd(2'd3, d_before);
        wr(2'd1, 32'h1); wr(2'd2, DEPTH * 16);
        wr(2'd0, 32'h8);
        wr(2'd2, 32'h40);
        wr(2'd0, 32'h4);
        wait_end(st);
        check("R5 run ends as self test", st, 32'h100);
        rd(2'd2, v); check("R5 length unchanged", v, DEPTH * 16);
        rd(2'd3, v); check("R5 no checksum result", v, d_before);

        // R6 protection gate
        @(negedge clk); prot_set = 1'b1; @(negedge clk); prot_set = 1'b0;
        rd(2'd0, v); check("R6 protected bit", v, 32'h1_0100);
        wr(2'd0, 32'h8);
        rd(2'd0, v); check("R6 self test refused", v, 32'h1_1000);
        wr(2'd0, 32'h4);
        rd(2'd0, v); check("R6 checksum refused", v, 32'h1_1000);
        wr(2'd0, 32'h1000);
        rd(2'd0, v); check("R3 perr W1C", v, 32'h1_0000);

        // R7 erase while protected, with R4 erase priority
        wr(2'd0, 32'h18);
        repeat (ERASE - 4) @(negedge clk);
        rd(2'd0, v); check("R7 erase still running", v, 32'h1_0000);
        wait_end(st);
        check("R4 R7 erase done, unprotected", st, 32'h100);

        // R8 mode bits and length low bits
        wr(2'd1, 32'h0000_0013); wr(2'd2, 32'h0000_0043);
        rd(2'd1, v); check("R8 addr kept", v, 32'h13);
        wr(2'd0, 32'h8); wait_end(st);
        check("R8 4 words from word 4", st, 32'h100);

        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule